// File: doc/BRIEF.md
# OTP Fuse Word Read Controller

This block is a register-mapped controller that fetches one 32-bit word from a one-time-programmable fuse array. Software sets up a timing register, writes a fuse word index into the control register and then kicks off the fetch by writing the read-control register. The controller then runs a timed sequence against a behavioural fuse-array port. First comes a quiet relax interval, then a read strobe, then a second relax interval, and last a request/valid handshake that returns the word.

While the sequence runs, a BUSY flag is visible in the control register. The result lands in a read-data register. A failed fetch loads a fixed poison word there and raises a sticky error flag, which software clears through a write-one-to-clear alias of the control register. A write-one-to-set alias also exists. The write-unlock field, the shadow-reload bit and the program-data register are held and read back, but they trigger no action.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: After reset every register reads zero, except the timing register, which reads 0x00091000 (relax count 1, read strobe count 9, program count 0).
- R2: The control register at byte offset 0x00 has the fuse index in bits 6:0, BUSY in bit 8, the error flag in bit 9, the reload bit in bit 10 and the unlock field in bits 31:16. A plain write replaces the index, reload and unlock fields and leaves bits 8 and 9 unchanged. All other bits read zero.
- R3: Writing offset 0x04 ORs the written value into the index, reload, unlock and error fields. Writing offset 0x08 clears each of those bits that is written as 1. BUSY is unaffected by both. Both aliases read back the control register.
- R4: The timing register at 0x10 holds bits 21:0: the program count in 11:0, the relax count in 15:12 and the read strobe count in 21:16. Bits 31:22 read zero.
- R5: Writing a 1 to bit 0 of offset 0x30 while idle starts a fetch at the index currently in the control register. BUSY reads 1 from the next cycle until the fetch completes. Offset 0x30 reads zero.
- R6: A fetch first spends relax+1 cycles with neither strobe nor request. It then holds fz_strobe for max(1, strobe+1-2*(relax+1)) cycles, then waits relax+1 quiet cycles, then holds fz_req until fz_valid. fz_addr carries the captured index throughout.
- R7: In the cycle after fz_valid is sampled with fz_req high, BUSY is 0 and offset 0x40 returns the fuse word.
- R8: A fetch fails when fz_err is high together with fz_valid, or when the index is 96 or more (no request is issued and the fetch ends right after the second relax). On failure, offset 0x40 returns 0xBADABADA and the error flag is set.
- R9: The error flag is sticky. Only writing bit 9 as 1 to the clear alias clears it, and a set event in the same cycle takes priority over the clear.
- R10: A start write or a timing write while BUSY does not start a fetch and does not change the timing register. It sets the error flag.
- R11: The unlock field has no effect on fetching. A fetch gives the same word with the field at 0 or at 0x3E77.
- R12: The program-data register at 0x20 stores and returns a full 32-bit value. The reload bit is stored only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset (read and write) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| fz_req | output | 1 | Fuse word request, held until fz_valid |
| fz_strobe | output | 1 | Fuse read strobe |
| fz_addr | output | 7 | Captured fuse word index |
| fz_valid | input | 1 | Fuse array response valid |
| fz_rdata | input | 32 | Fuse array word |
| fz_err | input | 1 | Fuse array read failure, with fz_valid |

## Verification
Fetches run under three timing settings:
- The reset default.
- A long strobe.
- A relax interval that swallows the whole strobe count.

These settings separate the strobe-width arithmetic from the minimum-width clamp. Fuse response latencies of 0 to 3 cycles show that the handshake, not a fixed delay, ends a fetch. Fuse error responses and out-of-range indices exercise both poison paths. Colliding start and timing writes during a fetch show that the running sequence is unharmed and that only the error flag reacts.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;
   localparam logic [7:0] OFS_CTRL = 8'h00;
   localparam logic [7:0] OFS_SET  = 8'h04;
   localparam logic [7:0] OFS_CLR  = 8'h08;
   localparam logic [7:0] OFS_TIME = 8'h10;
   localparam logic [7:0] OFS_PDAT = 8'h20;
   localparam logic [7:0] OFS_RCTL = 8'h30;
   localparam logic [7:0] OFS_RDAT = 8'h40;

   localparam int BUSY_BIT   = 8;
   localparam int ERR_BIT    = 9;
   localparam int RELOAD_BIT = 10;
   localparam int UNLOCK_LSB = 16;

   localparam logic [31:0] POISON_WORD = 32'hBADA_BADA;

   typedef enum logic [2:0] {
      SQ_IDLE, SQ_PRE, SQ_STRB, SQ_POST, SQ_FETCH
   } seq_st_e;
endpackage

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
   import fuse_rd_pkg::*;
#(
   parameter int ADDR_W     = 7,
   parameter int RELAX_W    = 4,
   parameter int SREAD_W    = 6,
   parameter int FUSE_WORDS = 96
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go,
   input  logic [ADDR_W-1:0]  go_addr,
   input  logic [RELAX_W-1:0] relax_cnt,
   input  logic [SREAD_W-1:0] sread_cnt,
   output logic               busy,
   output logic               done,
   output logic               fail,
   output logic [31:0]        word,
   output logic               fz_req,
   output logic               fz_strobe,
   output logic [ADDR_W-1:0]  fz_addr,
   input  logic               fz_valid,
   input  logic [31:0]        fz_rdata,
   input  logic               fz_err
);
   localparam int CW = ((SREAD_W > RELAX_W) ? SREAD_W : RELAX_W) + 2;

   seq_st_e          st_q;
   logic [CW-1:0]    cnt_q, wid_q, rlx_q;
   logic [CW-1:0]    total, twice, wid_m1;
   logic [ADDR_W-1:0] addr_q;
   logic             oor;

   // strobe width minus one, clamped so the strobe lasts at least one cycle
   always_comb begin
      total  = CW'(sread_cnt) + CW'(1);
      twice  = (CW'(relax_cnt) + CW'(1)) << 1;
      wid_m1 = (total > twice) ? (total - twice - CW'(1)) : '0;
   end

   generate
      if (FUSE_WORDS >= (1 << ADDR_W)) begin : g_full_array
         assign oor = 1'b0;
      end else begin : g_part_array
         assign oor = (addr_q >= ADDR_W'(FUSE_WORDS));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SQ_IDLE;
         cnt_q  <= '0;
         wid_q  <= '0;
         rlx_q  <= '0;
         addr_q <= '0;
      end else begin
         unique case (st_q)
            SQ_IDLE: if (go) begin
               st_q   <= SQ_PRE;
               cnt_q  <= CW'(relax_cnt);
               rlx_q  <= CW'(relax_cnt);
               wid_q  <= wid_m1;
               addr_q <= go_addr;
            end
            SQ_PRE: if (cnt_q == '0) begin
               st_q  <= SQ_STRB;
               cnt_q <= wid_q;
            end else cnt_q <= cnt_q - CW'(1);
            SQ_STRB: if (cnt_q == '0) begin
               st_q  <= SQ_POST;
               cnt_q <= rlx_q;
            end else cnt_q <= cnt_q - CW'(1);
            SQ_POST: if (cnt_q == '0) st_q <= SQ_FETCH;
               else cnt_q <= cnt_q - CW'(1);
            SQ_FETCH: if (done) st_q <= SQ_IDLE;
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign busy      = (st_q != SQ_IDLE);
   assign fz_strobe = (st_q == SQ_STRB);
   assign fz_req    = (st_q == SQ_FETCH) && !oor;
   assign fz_addr   = addr_q;
   assign done      = (st_q == SQ_FETCH) && (oor || fz_valid);
   assign fail      = done && (oor || fz_err);
   assign word      = fail ? POISON_WORD : fz_rdata;
endmodule

// File: rtl/fuse_rd_regs.sv
module fuse_rd_regs
   import fuse_rd_pkg::*;
#(
   parameter int ADDR_W    = 7,
   parameter int RELAX_W   = 4,
   parameter int SREAD_W   = 6,
   parameter int SPROG_W   = 12,
   parameter int BUS_AW    = 8,
   parameter int RST_RELAX = 1,
   parameter int RST_SREAD = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic [BUS_AW-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic               seq_busy,
   input  logic               seq_done,
   input  logic               seq_fail,
   input  logic [31:0]        seq_word,
   output logic               go,
   output logic [ADDR_W-1:0]  fuse_addr,
   output logic [RELAX_W-1:0] relax_cnt,
   output logic [SREAD_W-1:0] sread_cnt,
   output logic               err_flag,
   output logic               clr_err,
   output logic               tmg_wr,
   output logic [31:0]        tmg_view
);
   localparam int RELAX_LSB = SPROG_W;
   localparam int SREAD_LSB = SPROG_W + RELAX_W;
   localparam int TIMING_W  = SREAD_LSB + SREAD_W;
   localparam logic [TIMING_W-1:0] TIMING_RST =
      TIMING_W'((RST_SREAD << SREAD_LSB) | (RST_RELAX << RELAX_LSB));

   logic [ADDR_W-1:0]   addr_q;
   logic                reload_q, err_q;
   logic [15:0]         unlock_q;
   logic [TIMING_W-1:0] timing_q;
   logic [31:0]         pdat_q, rdat_q, ctrl_view;
   logic                hit_ctrl, hit_set, hit_clr, hit_pdat, start_wr, err_set;

   assign hit_ctrl = bus_wr && (bus_addr == BUS_AW'(OFS_CTRL));
   assign hit_set  = bus_wr && (bus_addr == BUS_AW'(OFS_SET));
   assign hit_clr  = bus_wr && (bus_addr == BUS_AW'(OFS_CLR));
   assign hit_pdat = bus_wr && (bus_addr == BUS_AW'(OFS_PDAT));
   assign tmg_wr   = bus_wr && (bus_addr == BUS_AW'(OFS_TIME));
   assign start_wr = bus_wr && (bus_addr == BUS_AW'(OFS_RCTL)) && bus_wdata[0];
   assign go       = start_wr && !seq_busy;
   assign clr_err  = hit_clr && bus_wdata[ERR_BIT];
   assign err_set  = seq_fail || (seq_busy && (start_wr || tmg_wr))
                   || (hit_set && bus_wdata[ERR_BIT]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         reload_q <= 1'b0;
         unlock_q <= '0;
         err_q    <= 1'b0;
         timing_q <= TIMING_RST;
         pdat_q   <= '0;
         rdat_q   <= '0;
      end else begin
         if (hit_ctrl) begin
            addr_q   <= bus_wdata[ADDR_W-1:0];
            reload_q <= bus_wdata[RELOAD_BIT];
            unlock_q <= bus_wdata[UNLOCK_LSB +: 16];
         end else if (hit_set) begin
            addr_q   <= addr_q | bus_wdata[ADDR_W-1:0];
            reload_q <= reload_q | bus_wdata[RELOAD_BIT];
            unlock_q <= unlock_q | bus_wdata[UNLOCK_LSB +: 16];
         end else if (hit_clr) begin
            addr_q   <= addr_q & ~bus_wdata[ADDR_W-1:0];
            reload_q <= reload_q & ~bus_wdata[RELOAD_BIT];
            unlock_q <= unlock_q & ~bus_wdata[UNLOCK_LSB +: 16];
         end
         if (err_set)      err_q <= 1'b1;
         else if (clr_err) err_q <= 1'b0;
         if (tmg_wr && !seq_busy) timing_q <= bus_wdata[TIMING_W-1:0];
         if (hit_pdat) pdat_q <= bus_wdata;
         if (seq_done) rdat_q <= seq_word;
      end
   end

   always_comb begin
      ctrl_view                      = '0;
      ctrl_view[ADDR_W-1:0]          = addr_q;
      ctrl_view[BUSY_BIT]            = seq_busy;
      ctrl_view[ERR_BIT]             = err_q;
      ctrl_view[RELOAD_BIT]          = reload_q;
      ctrl_view[UNLOCK_LSB +: 16]    = unlock_q;
   end

   assign tmg_view = 32'(timing_q);

   always_comb begin
      if (bus_addr == BUS_AW'(OFS_CTRL) || bus_addr == BUS_AW'(OFS_SET) ||
          bus_addr == BUS_AW'(OFS_CLR))        bus_rdata = ctrl_view;
      else if (bus_addr == BUS_AW'(OFS_TIME))  bus_rdata = tmg_view;
      else if (bus_addr == BUS_AW'(OFS_PDAT))  bus_rdata = pdat_q;
      else if (bus_addr == BUS_AW'(OFS_RDAT))  bus_rdata = rdat_q;
      else                                     bus_rdata = '0;
   end

   assign fuse_addr = addr_q;
   assign relax_cnt = timing_q[RELAX_LSB +: RELAX_W];
   assign sread_cnt = timing_q[SREAD_LSB +: SREAD_W];
   assign err_flag  = err_q;
endmodule

// File: rtl/fuse_rd_ctrl.sv
module fuse_rd_ctrl
   import fuse_rd_pkg::*;
#(
   parameter int ADDR_W     = 7,
   parameter int RELAX_W    = 4,
   parameter int SREAD_W    = 6,
   parameter int SPROG_W    = 12,
   parameter int BUS_AW     = 8,
   parameter int FUSE_WORDS = 96,
   parameter int RST_RELAX  = 1,
   parameter int RST_SREAD  = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              fz_req,
   output logic              fz_strobe,
   output logic [ADDR_W-1:0] fz_addr,
   input  logic              fz_valid,
   input  logic [31:0]       fz_rdata,
   input  logic              fz_err
);
   generate
      if (ADDR_W < 1 || ADDR_W > BUSY_BIT) begin : g_bad_addr_w
         $error("fuse index width must fit below the busy bit");
      end
      if (SPROG_W + RELAX_W + SREAD_W > 32) begin : g_bad_timing_w
         $error("timing fields exceed one word");
      end
      if (FUSE_WORDS < 1 || FUSE_WORDS > (1 << ADDR_W)) begin : g_bad_words
         $error("fuse word count out of index range");
      end
      if (BUS_AW < 7) begin : g_bad_bus_aw
         $error("register offset bus too narrow");
      end
   endgenerate

   logic               seq_busy, seq_done, seq_fail, go;
   logic [31:0]        seq_word, tmg_view;
   logic [ADDR_W-1:0]  fuse_addr;
   logic [RELAX_W-1:0] relax_cnt;
   logic [SREAD_W-1:0] sread_cnt;
   logic               err_flag, clr_err, tmg_wr;
   logic [7:0]         fz_addr_ext;

   assign fz_addr_ext = 8'(fz_addr);

   fuse_rd_regs #(
      .ADDR_W(ADDR_W), .RELAX_W(RELAX_W), .SREAD_W(SREAD_W), .SPROG_W(SPROG_W),
      .BUS_AW(BUS_AW), .RST_RELAX(RST_RELAX), .RST_SREAD(RST_SREAD)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .seq_busy(seq_busy),
      .seq_done(seq_done), .seq_fail(seq_fail), .seq_word(seq_word), .go(go),
      .fuse_addr(fuse_addr), .relax_cnt(relax_cnt), .sread_cnt(sread_cnt),
      .err_flag(err_flag), .clr_err(clr_err), .tmg_wr(tmg_wr), .tmg_view(tmg_view)
   );

   fuse_rd_seq #(
      .ADDR_W(ADDR_W), .RELAX_W(RELAX_W), .SREAD_W(SREAD_W), .FUSE_WORDS(FUSE_WORDS)
   ) seq_i (
      .clk(clk), .rst_n(rst_n), .go(go), .go_addr(fuse_addr),
      .relax_cnt(relax_cnt), .sread_cnt(sread_cnt), .busy(seq_busy),
      .done(seq_done), .fail(seq_fail), .word(seq_word), .fz_req(fz_req),
      .fz_strobe(fz_strobe), .fz_addr(fz_addr), .fz_valid(fz_valid),
      .fz_rdata(fz_rdata), .fz_err(fz_err)
   );
endmodule

// File: rtl/fuse_rd_chk.sv
module fuse_rd_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        busy,
   input logic        go,
   input logic        err_flag,
   input logic        clr_err,
   input logic        tmg_wr,
   input logic [31:0] tmg_view,
   input logic        fz_req,
   input logic        fz_valid,
   input logic        fz_strobe,
   input logic [7:0]  fz_addr_ext
);
   assert_strobe_req_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(fz_strobe && fz_req));

   assert_strobe_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fz_strobe |-> busy);

   assert_go_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> busy);

   assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fz_req && !fz_valid) |=> (fz_req && $stable(fz_addr_ext)));

   assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fz_req && fz_valid) |=> !busy);

   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !clr_err) |=> err_flag);

   assert_timing_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(tmg_view));

   assert_busy_write_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && tmg_wr) |=> err_flag);
endmodule

bind fuse_rd_ctrl fuse_rd_chk chk_i (
   .clk(clk), .rst_n(rst_n), .busy(seq_busy), .go(go), .err_flag(err_flag),
   .clr_err(clr_err), .tmg_wr(tmg_wr), .tmg_view(tmg_view), .fz_req(fz_req),
   .fz_valid(fz_valid), .fz_strobe(fz_strobe), .fz_addr_ext(fz_addr_ext)
);

// File: tb/fuse_rd_ctrl_tb_top.sv
module fuse_rd_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] POISON = 32'hBADA_BADA;
   localparam int N_WORDS = 96;

   logic clk = 1'b0;
   logic rst_n;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic        bus_wr;
   logic [7:0]  bus_addr;
   logic [31:0] bus_wdata, bus_rdata;
   logic        fz_req, fz_strobe, fz_valid, fz_err;
   logic [6:0]  fz_addr;
   logic [31:0] fz_rdata;

   fuse_rd_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fz_req(fz_req),
      .fz_strobe(fz_strobe), .fz_addr(fz_addr), .fz_valid(fz_valid),
      .fz_rdata(fz_rdata), .fz_err(fz_err)
   );

   int n_cmp = 0, n_bad = 0;
   bit fin = 0;
   int fuse_lat = 0, lat_cnt = 0, rr = 0, strobe_cycles = 0, req_cycles = 0;
   logic [6:0] bad_addr = 7'h7F;

   // reference model state
   logic [6:0]  m_addr, m_fa;
   logic        m_rel, m_err, m_active;
   logic [15:0] m_unl;
   logic [31:0] m_tim, m_pd, m_rd;
   int          m_t, m_r1, m_w;

   function automatic logic [31:0] fuse_word(input logic [6:0] a);
      return {a, 1'b1, ~a, 1'b0, a, 1'b1, a ^ 7'h55, 1'b0};
   endfunction

   function automatic logic [31:0] exp_rdata(input logic [7:0] a);
      case (a)
         8'h00, 8'h04, 8'h08: return {m_unl, 5'b0, m_rel, m_err, m_active, 1'b0, m_addr};
         8'h10: return m_tim;
         8'h20: return m_pd;
         8'h40: return m_rd;
         default: return 32'h0;
      endcase
   endfunction

   function automatic string addr_tag(input logic [7:0] a);
      case (a)
         8'h00: return "R2";
         8'h04, 8'h08: return "R3";
         8'h10: return "R4";
         8'h20: return "R12";
         8'h30: return "R5";
         8'h40: return "R7";
         default: return "R2";
      endcase
   endfunction

   function automatic bit exp_strobe();
      return m_active && m_t >= m_r1 && m_t < m_r1 + m_w;
   endfunction

   function automatic bit exp_req();
      return m_active && m_t >= 2*m_r1 + m_w && m_fa < N_WORDS;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_addr = '0; m_fa = '0; m_rel = 0; m_err = 0; m_active = 0;
      m_unl = '0; m_tim = 32'h0009_1000; m_pd = '0; m_rd = '0;
      m_t = 0; m_r1 = 1; m_w = 1;
   endtask

   task automatic model_step(input bit w, input logic [7:0] a, input logic [31:0] d);
      bit busy, in_fetch, oor, done, fail, tw, st, eset, eclr;
      int rl, tot;
      busy     = m_active;
      in_fetch = m_active && m_t >= 2*m_r1 + m_w;
      oor      = (m_fa >= N_WORDS);
      done     = in_fetch && (oor || fz_valid);
      fail     = done && (oor || fz_err);
      tw       = w && a == 8'h10;
      st       = w && a == 8'h30 && d[0];
      eset     = fail || (busy && (tw || st)) || (w && a == 8'h04 && d[9]);
      eclr     = w && a == 8'h08 && d[9];
      if (st && !busy) begin
         rl = int'(m_tim[15:12]) + 1;
         tot = int'(m_tim[21:16]) + 1;
         m_r1 = rl;
         m_w = (tot - 2*rl > 0) ? tot - 2*rl : 1;
         m_fa = m_addr;
         m_t = 0;
         m_active = 1;
      end else if (done) begin
         m_rd = fail ? POISON : fz_rdata;
         m_active = 0;
      end else if (m_active) m_t++;
      if (w && a == 8'h00) begin
         m_addr = d[6:0]; m_rel = d[10]; m_unl = d[31:16];
      end else if (w && a == 8'h04) begin
         m_addr |= d[6:0]; m_rel |= d[10]; m_unl |= d[31:16];
      end else if (w && a == 8'h08) begin
         m_addr &= ~d[6:0]; m_rel &= ~d[10]; m_unl &= ~d[31:16];
      end
      if (tw && !busy) m_tim = d & 32'h003F_FFFF;
      if (w && a == 8'h20) m_pd = d;
      if (eset) m_err = 1; else if (eclr) m_err = 0;
   endtask

   task automatic compare();
      string tg;
      tg = addr_tag(bus_addr);
      check({tg, " register read"}, bus_rdata, exp_rdata(bus_addr));
      check("R6 strobe", 32'(fz_strobe), 32'(exp_strobe()));
      check("R6 request", 32'(fz_req), 32'(exp_req()));
      if (exp_strobe() || exp_req()) check("R6 fuse address", 32'(fz_addr), 32'(m_fa));
      if (fz_strobe) strobe_cycles++;
      if (fz_req) req_cycles++;
   endtask

   task automatic fuse_drive();
      if (fz_req) begin
         if (lat_cnt >= fuse_lat) begin
            fz_valid = 1'b1;
            fz_rdata = fuse_word(fz_addr);
            fz_err   = (fz_addr == bad_addr);
         end else lat_cnt++;
      end else begin
         fz_valid = 1'b0; fz_err = 1'b0; lat_cnt = 0;
      end
   endtask

   task automatic tick(input bit w, input logic [7:0] a, input logic [31:0] d);
      bus_wr = w; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      model_step(w, a, d);
      @(negedge clk);
      compare();
      fuse_drive();
   endtask

   task automatic tick_idle();
      logic [7:0] a;
      case (rr)
         0: a = 8'h00; 1: a = 8'h10; 2: a = 8'h40;
         3: a = 8'h20; 4: a = 8'h30; default: a = 8'h04;
      endcase
      rr = (rr + 1) % 6;
      tick(0, a, 32'h0);
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      tick(0, a, 32'h0);
      v = bus_rdata;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 500 && m_active; i++) tick_idle();
   endtask

   task automatic do_read(input logic [6:0] idx, input logic [15:0] unl);
      tick(1, 8'h00, {unl, 9'b0, idx});
      strobe_cycles = 0; req_cycles = 0;
      tick(1, 8'h30, 32'h1);
      wait_idle();
   endtask

   initial begin
      logic [31:0] v;
      rst_n = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
      fz_valid = 0; fz_err = 0; fz_rdata = 0;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset values
      rd(8'h10, v); check("R1 timing reset", v, 32'h0009_1000);
      rd(8'h00, v); check("R1 control reset", v, 32'h0);
      rd(8'h40, v); check("R1 read data reset", v, 32'h0);
      rd(8'h20, v); check("R1 program data reset", v, 32'h0);
      // R2 plain control write
      tick(1, 8'h00, 32'hFFFF_FFFF);
      rd(8'h00, v); check("R2 control fields", v, 32'hFFFF_047F);
      // R3 aliases
      tick(1, 8'h08, 32'hFFFF_0400);
      tick(1, 8'h04, 32'h0000_0300);
      rd(8'h04, v); check("R3 set alias", v, 32'h0000_027F);
      tick(1, 8'h08, 32'h0000_027A);
      rd(8'h08, v); check("R3 clear alias", v, 32'h0000_0005);
      // R5 R7 default timing read
      fuse_lat = 2;
      do_read(7'h12, 16'h0);
      rd(8'h40, v); check("R7 fuse word", v, fuse_word(7'h12));
      check("R6 default strobe width", 32'(strobe_cycles), 32'd6);
      rd(8'h30, v); check("R5 read control reads zero", v, 32'h0);
      // R4 R11 long strobe, unlock key
      tick(1, 8'h10, 32'hFFD4_3ABC);
      rd(8'h10, v); check("R4 timing fields", v, 32'h0014_3ABC);
      fuse_lat = 0;
      do_read(7'h33, 16'h3E77);
      rd(8'h40, v); check("R11 read with unlock key", v, fuse_word(7'h33));
      check("R6 long strobe width", 32'(strobe_cycles), 32'd13);
      do_read(7'h33, 16'h0);
      rd(8'h40, v); check("R11 read with unlock zero", v, fuse_word(7'h33));
      // R10 collisions while busy
      tick(1, 8'h00, 32'h3);
      tick(1, 8'h30, 32'h1);
      tick(1, 8'h30, 32'h1);
      tick(1, 8'h10, 32'hFFFF_FFFF);
      wait_idle();
      rd(8'h10, v); check("R10 timing unchanged", v, 32'h0014_3ABC);
      rd(8'h00, v); check("R10 error raised", v, 32'h0000_0203);
      rd(8'h40, v); check("R10 running read intact", v, fuse_word(7'h03));
      tick(1, 8'h08, 32'h200);
      // R6 clamp: relax swallows the strobe count
      tick(1, 8'h10, 32'h0005_7000);
      fuse_lat = 3;
      do_read(7'h02, 16'h0);
      check("R6 clamped strobe width", 32'(strobe_cycles), 32'd1);
      rd(8'h40, v); check("R7 fuse word late valid", v, fuse_word(7'h02));
      // R8 error response
      tick(1, 8'h10, 32'h0009_1000);
      bad_addr = 7'h40; fuse_lat = 1;
      do_read(7'h40, 16'h0);
      rd(8'h40, v); check("R8 poison on fuse error", v, POISON);
      // R9 stickiness
      repeat (4) tick_idle();
      tick(1, 8'h00, 32'h0);
      tick(1, 8'h08, 32'h1);
      rd(8'h00, v); check("R9 error held", v, 32'h0000_0200);
      tick(1, 8'h08, 32'h200);
      rd(8'h00, v); check("R9 error cleared", v, 32'h0);
      // R8 out-of-range index
      do_read(7'h70, 16'h0);
      rd(8'h40, v); check("R8 poison out of range", v, POISON);
      check("R8 no request out of range", 32'(req_cycles), 32'd0);
      rd(8'h00, v); check("R8 error set", v, 32'h0000_0270);
      tick(1, 8'h08, 32'h200);
      // last implemented word
      bad_addr = 7'h7F;
      do_read(7'd95, 16'h0);
      rd(8'h40, v); check("R8 last valid word", v, fuse_word(7'd95));
      // R12 program data and reload
      tick(1, 8'h20, 32'hCAFE_F00D);
      rd(8'h20, v); check("R12 program data", v, 32'hCAFE_F00D);
      tick(1, 8'h04, 32'h400);
      rd(8'h00, v); check("R12 reload held", v, 32'h0000_045F);
      repeat (6) tick_idle();
      fin = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!fin) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule